// File: doc/BRIEF.md
# Two-Flag Word Link with Overrun Detection

This block moves parallel words from a producer to a consumer over a reduced handshake built from two flags. A small sender state machine takes a word from a push port. It puts the word on an internal link bus, raises a data-valid flag one cycle later, and waits only for the receiver's acknowledge before it drops the flag and clears the bus. It does not wait for the acknowledge to fall before it accepts the next word.

A small receiver state machine watches the data-valid flag as a level and acts on its rising edge. On that edge it copies the word into a one-word holding slot, pulses a word-ready strobe and raises its acknowledge. It lowers the acknowledge once the data-valid flag has gone low. The consumer empties the slot with a pop input. If a new word lands while the slot is still full, a sticky overrun flag is raised and the new word replaces the old one. The flag stays set until an explicit clear or a reset. Both ends share one clock, and the link flags and bus are brought out so the handshake can be observed.

Top module: `hs_link`

## Requirements
- R1: While rst_n is low at a clock edge, and after that edge, push_ready is 1, link_dav, link_ack, rx_stb, rx_full and overrun are 0, and link_data is all zeros.
- R2: A push accepted at an edge (push_valid high while push_ready is 1) puts push_word on link_data at that edge. link_dav rises one edge later, and link_data does not change while link_dav is high.
- R3: At the first edge where the receiver sees link_dav high after seeing it low, rx_word takes link_data, rx_stb is 1 for exactly that one cycle, rx_full becomes 1 and link_ack becomes 1.
- R4: A link_dav that stays high for several cycles produces one rx_stb pulse only.
- R5: At the first edge where the sender sees link_ack high while link_dav is high, link_dav falls, link_data returns to zero and push_ready returns to 1. A new push may then be accepted even though link_ack is still high.
- R6: link_ack falls at the edge after the receiver sees link_dav low.
- R7: pop at an edge with no capture clears rx_full. A pop at the same edge as a capture leaves rx_full at 1 and raises no overrun.
- R8: A capture while rx_full is 1 and pop is 0 sets overrun, and rx_word takes the new word.
- R9: overrun stays set until ovr_clr is high at an edge or reset. If an overrun is raised at the same edge as ovr_clr, overrun ends up 1.
- R10: push_valid while push_ready is 0 is ignored: link_data keeps the word in flight, and the ignored word is never captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ends |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | 1 | Producer offers push_word |
| push_word | input | WIDTH | Word to send |
| push_ready | output | 1 | Sender idle, a push is taken this cycle |
| pop | input | 1 | Consumer empties the holding slot |
| ovr_clr | input | 1 | Clears the sticky overrun flag |
| rx_word | output | WIDTH | Last word captured |
| rx_stb | output | 1 | One-cycle pulse on each capture |
| rx_full | output | 1 | Holding slot holds an unread word |
| overrun | output | 1 | Sticky: a word was lost |
| link_dav | output | 1 | Data-valid flag on the link |
| link_ack | output | 1 | Receiver acknowledge on the link |
| link_data | output | WIDTH | Link bus driven by the sender |

## Verification
The bench builds the block with WIDTH = 8. This is wide enough that the old word, the new word and the cleared bus can be told apart in every overrun and bus-clear case. The same bench runs two stimulus phases. In the first, pops are rare, so back-to-back captures into a full slot, overruns, and clears that coincide with a new overrun all occur many times. In the second, pops are frequent, so pops that land on a capture edge and pushes offered while the sender is busy are common. A reset in the middle of the run brings the reset state back into view.

// File: rtl/hs_pkg.sv
// Shared state encodings for the two-flag word link.
package hs_pkg;

    // Sender phases: idle, bus driven ahead of the flag, flag raised.
    typedef enum logic [1:0] {
        TX_IDLE  = 2'b00,
        TX_SETUP = 2'b01,
        TX_VALID = 2'b11
    } tx_state_t;

    // Receiver phases: waiting for a new flag, acknowledge raised.
    typedef enum logic {
        RX_WAIT  = 1'b0,
        RX_ACKED = 1'b1
    } rx_state_t;

endpackage

// File: rtl/hs_sender.sv
// Sender end of the link.
// Takes one word from the push port when idle, drives it on the bus for a
// cycle, then raises the data-valid flag. When the acknowledge is seen, it
// drops the flag, clears the bus and becomes idle again. It never waits for
// the acknowledge to fall.
// Assumes the acknowledge is low whenever this FSM enters TX_VALID.
module hs_sender
    import hs_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_valid,
    input  logic [WIDTH-1:0] push_word,
    output logic             push_ready,
    input  logic             ack_in,
    output logic             dav_out,
    output logic [WIDTH-1:0] data_out
);

    tx_state_t        state;
    logic [WIDTH-1:0] bus_q;

    // Flag and ready decode straight from the state.
    always_comb begin
        push_ready = (state == TX_IDLE);
        dav_out    = (state == TX_VALID);
        data_out   = bus_q;
    end

    // Phase sequencing and bus register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TX_IDLE;
            bus_q <= '0;
        end else begin
            unique case (state)
                TX_IDLE: begin
                    if (push_valid) begin
                        bus_q <= push_word;
                        state <= TX_SETUP;
                    end
                end
                TX_SETUP: state <= TX_VALID;
                TX_VALID: begin
                    if (ack_in) begin
                        bus_q <= '0;
                        state <= TX_IDLE;
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/hs_rx_fsm.sv
// Receiver handshake FSM.
// Samples the data-valid flag as a level and signals one capture on its
// rising edge. It raises the acknowledge at that capture and lowers it
// once the flag has been seen low.
// Assumes the flag is low for at least one cycle between words.
module hs_rx_fsm
    import hs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dav_in,
    output logic capture,
    output logic ack_out
);

    rx_state_t state;
    logic      dav_q;

    // Capture only on a low-to-high flag seen while waiting.
    always_comb begin
        capture = (state == RX_WAIT) && dav_in && !dav_q;
        ack_out = (state == RX_ACKED);
    end

    // Flag history and acknowledge phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RX_WAIT;
            dav_q <= 1'b0;
        end else begin
            dav_q <= dav_in;
            unique case (state)
                RX_WAIT:  if (capture) state <= RX_ACKED;
                RX_ACKED: if (!dav_in) state <= RX_WAIT;
                default:  state <= RX_WAIT;
            endcase
        end
    end

endmodule

// File: rtl/hs_slot.sv
// One-word holding slot on the receive side.
// Stores each captured word, pulses a strobe and tracks occupancy. A capture
// into an occupied slot that is not emptied in the same cycle raises a
// sticky overrun flag; the new word overwrites the old one.
// Assumes capture is a single-cycle pulse.
module hs_slot #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [WIDTH-1:0] data_in,
    input  logic             pop,
    input  logic             ovr_clr,
    output logic [WIDTH-1:0] rx_word,
    output logic             rx_stb,
    output logic             rx_full,
    output logic             overrun
);

    logic lost;

    // A word is lost when the slot is occupied and not being emptied.
    always_comb lost = capture && rx_full && !pop;

    // Slot contents, occupancy, strobe and sticky error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_word <= '0;
            rx_stb  <= 1'b0;
            rx_full <= 1'b0;
            overrun <= 1'b0;
        end else begin
            rx_stb <= capture;
            if (capture) begin
                rx_word <= data_in;
                rx_full <= 1'b1;
            end else if (pop) begin
                rx_full <= 1'b0;
            end
            if (lost)         overrun <= 1'b1;
            else if (ovr_clr) overrun <= 1'b0;
        end
    end

endmodule

// File: rtl/hs_link.sv
// Top of the two-flag word link: sender, receiver FSM and holding slot
// on one clock. The link flags and bus are brought out for observation.
module hs_link #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_valid,
    input  logic [WIDTH-1:0] push_word,
    output logic             push_ready,
    input  logic             pop,
    input  logic             ovr_clr,
    output logic [WIDTH-1:0] rx_word,
    output logic             rx_stb,
    output logic             rx_full,
    output logic             overrun,
    output logic             link_dav,
    output logic             link_ack,
    output logic [WIDTH-1:0] link_data
);

    logic capture;

    hs_sender #(.WIDTH(WIDTH)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (push_valid),
        .push_word  (push_word),
        .push_ready (push_ready),
        .ack_in     (link_ack),
        .dav_out    (link_dav),
        .data_out   (link_data)
    );

    hs_rx_fsm u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .dav_in  (link_dav),
        .capture (capture),
        .ack_out (link_ack)
    );

    hs_slot #(.WIDTH(WIDTH)) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .data_in (link_data),
        .pop     (pop),
        .ovr_clr (ovr_clr),
        .rx_word (rx_word),
        .rx_stb  (rx_stb),
        .rx_full (rx_full),
        .overrun (overrun)
    );

endmodule

// File: rtl/hs_link_chk.sv
// Protocol checker for hs_link, attached with bind.
module hs_link_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pop,
    input logic             ovr_clr,
    input logic             rx_stb,
    input logic             rx_full,
    input logic             overrun,
    input logic             link_dav,
    input logic             link_ack,
    input logic [WIDTH-1:0] link_data
);

    AST_BUS_STABLE_AT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_dav) |-> $stable(link_data)); // R2

    AST_FLAG_HELD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (link_dav && !link_ack) |=> (link_dav && $stable(link_data))); // R2

    AST_STB_SETS_FULL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        rx_stb |-> (rx_full && link_ack)); // R3

    AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_stb |=> !rx_stb); // R4

    AST_FLAG_DROPS_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (link_dav && link_ack) |=> (!link_dav && link_data == '0)); // R5

    AST_ACK_FOLLOWS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (link_ack && !link_dav) |=> !link_ack); // R6

    AST_POP_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !link_dav) |=> !rx_full); // R7

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ovr_clr) |=> overrun); // R9

endmodule

bind hs_link hs_link_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pop       (pop),
    .ovr_clr   (ovr_clr),
    .rx_stb    (rx_stb),
    .rx_full   (rx_full),
    .overrun   (overrun),
    .link_dav  (link_dav),
    .link_ack  (link_ack),
    .link_data (link_data)
);

// File: tb/sim_hs_link.sv
// Bench for hs_link: behavioural reference model compared every clock.
module sim_hs_link;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         push_valid = 1'b0;
    logic [W-1:0] push_word = '0;
    logic         pop = 1'b0;
    logic         ovr_clr = 1'b0;
    logic         push_ready, rx_stb, rx_full, overrun, link_dav, link_ack;
    logic [W-1:0] rx_word, link_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    hs_link #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_word(push_word),
        .push_ready(push_ready), .pop(pop), .ovr_clr(ovr_clr), .rx_word(rx_word),
        .rx_stb(rx_stb), .rx_full(rx_full), .overrun(overrun), .link_dav(link_dav),
        .link_ack(link_ack), .link_data(link_data)
    );

    // Reference model: phase of the word in flight (-1 none), counters.
    int           ph = -1;
    int           ack_left = 0;
    logic [W-1:0] wd = '0;
    logic [W-1:0] m_word = '0;
    bit           m_stb = 0, m_full = 0, m_ovr = 0;
    bit           was_reset = 1;
    bit           was_busy_push = 0;

    always @(posedge clk) begin
        bit cap;
        bit lost;
        was_reset     = !rst_n;
        was_busy_push = push_valid && (ph != -1);
        if (!rst_n) begin
            ph = -1; ack_left = 0; wd = '0; m_word = '0;
            m_stb = 0; m_full = 0; m_ovr = 0;
        end else begin
            cap  = (ph == 1);
            lost = cap && m_full && !pop;
            if (ph == -1) begin
                if (push_valid) begin ph = 0; wd = push_word; end
            end else if (ph == 2) begin
                ph = -1; wd = '0;
            end else begin
                ph = ph + 1;
            end
            m_stb = cap;
            if (cap) begin m_word = wd; m_full = 1; end
            else if (pop) m_full = 0;
            if (lost) m_ovr = 1;
            else if (ovr_clr) m_ovr = 0;
            if (cap) ack_left = 2;
            else if (ack_left > 0) ack_left = ack_left - 1;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        string rq;
        rq = was_reset ? "R1" : "R5";
        chk(rq, "push_ready", int'(push_ready), int'(ph == -1));
        rq = was_reset ? "R1" : "R2";
        chk(rq, "link_dav", int'(link_dav), int'(ph >= 1));
        rq = was_reset ? "R1" : (was_busy_push ? "R10" : "R2");
        chk(rq, "link_data", int'(link_data), int'(wd));
        rq = was_reset ? "R1" : "R6";
        chk(rq, "link_ack", int'(link_ack), int'(ack_left > 0));
        rq = was_reset ? "R1" : "R4";
        chk(rq, "rx_stb", int'(rx_stb), int'(m_stb));
        rq = was_reset ? "R1" : (m_stb ? "R3" : "R8");
        chk(rq, "rx_word", int'(rx_word), int'(m_word));
        rq = was_reset ? "R1" : "R7";
        chk(rq, "rx_full", int'(rx_full), int'(m_full));
        rq = was_reset ? "R1" : "R9";
        chk(rq, "overrun", int'(overrun), int'(m_ovr));
    endtask

    // Stimulus: LFSR-driven inputs in two phases, with a mid-run reset.
    initial begin
        logic [15:0] lf;
        lf = 16'hACE1;
        for (int cyc = 0; cyc < 4000; cyc++) begin
            @(negedge clk);
            compare_all();
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            rst_n      = !((cyc < 3) || (cyc >= 1800 && cyc < 1803));
            push_valid = lf[0] | lf[5];
            push_word  = lf[15:8] ^ lf[7:0];
            if (cyc < 2000) pop = (lf[3:0] == 4'h0);
            else            pop = lf[2];
            ovr_clr = (lf[11:9] == 3'b101);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule